// File: doc/BRIEF.md
# Clock Mode and Reset Release Sequencer

This block sits between a board-level reset and a processor core that can run its clock in one of two ways: at half the input rate, or doubled by a phase-locked loop. While the external reset is held, it samples a mode-select pin through a two-flop synchronizer and latches the result. Once the reset lifts, it produces the core's reset and a per-cycle clock enable that suit the chosen mode.

In half-rate mode the loop stays off. The core reset lifts one cycle after the external reset, and the clock enable alternates every input cycle, so the core advances on every second cycle. In doubling mode the clock enable stays high. A cycle counter stands in for the analog loop: it raises a lock flag after a fixed number of input cycles. The core reset is then held for a further safety margin before it is released. Asserting the external reset at any time starts the whole sequence over.

Top module: `clkmode_rst_seq`

## Requirements
- R1: With the latched mode low (half-rate, encoding 0), `core_rst_n_o` goes high at the first rising edge that samples `ext_rst_n_i` high, and `pll_locked_o` stays low for as long as the external reset stays high.
- R2: With the latched mode high (doubling, encoding 1), `clk_en_o` is high on every cycle after the first rising edge that samples `ext_rst_n_i` high.
- R3: The mode is latched only on edges that sample `ext_rst_n_i` low. Changes on `mode_sel_i` after release have no effect on any output until the next reset.
- R4: In doubling mode, `pll_locked_o` rises after exactly LOCK_CYCLES (default 2200) rising edges that sample `ext_rst_n_i` high. It then stays high until the next reset.
- R5: In doubling mode, `core_rst_n_o` stays low while `pll_locked_o` is low. It rises exactly MARGIN (default 3) cycles after `pll_locked_o` rises.
- R6: In half-rate mode, `clk_en_o` is 1 after the first edge that samples the reset released and inverts on every following cycle.
- R7: Any rising edge that samples `ext_rst_n_i` low drives `core_rst_n_o`, `pll_locked_o` and `clk_en_o` low. It also clears the lock count, so after the next release the lock time of R4 is counted from zero.
- R8: `mode_sel_i` passes two synchronizer flops before the latch. It must be steady for at least three reset edges before release. A change made during only the last reset cycle does not take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input reference clock |
| ext_rst_n_i | input | 1 | External reset, active low, sampled synchronously |
| mode_sel_i | input | 1 | Clock mode pin: 0 half-rate, 1 doubling |
| core_rst_n_o | output | 1 | Reset to the core, active low |
| pll_locked_o | output | 1 | Modelled loop lock flag |
| clk_en_o | output | 1 | Per-cycle advance enable for the core |

## Verification
The hardest states to reach from the ports are the lock-counter restart and the synchronizer latency. The bench drops the external reset partway through a doubling-mode count, after a thousand cycles, and after the flag has already risen. It then checks that the lock flag arrives after the full count again, and not after the remainder. For the synchronizer latency, the bench flips the mode pin on the very last reset cycle. It tells the old mode from the new one by the core reset level and the clock enable on the first two cycles after release.

// File: rtl/cmrs_pkg.sv
// Shared types for the clock mode and reset release sequencer.
package cmrs_pkg;
    // Clock mode as seen on the mode-select pin.
    typedef enum logic {
        MODE_HALF   = 1'b0,
        MODE_DOUBLE = 1'b1
    } clk_mode_e;
endpackage

// File: rtl/cmrs_sync.sv
// Multi-stage synchronizer for one asynchronous level input.
// Assumes: STAGES >= 2. The flops have no reset on purpose, because the
// value must keep flowing while the external reset is held.
module cmrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the input level through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmrs_mode_latch.sv
// Holds the clock mode. It loads the synchronized pin on every reset edge
// and freezes it once reset is released.
// Assumes: the pin is stable for at least the synchronizer depth plus one
// reset edge before release.
module cmrs_mode_latch
    import cmrs_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_n_i,
    input  logic      mode_sync_i,
    output clk_mode_e mode_o
);
    clk_mode_e mode_q;

    // Load during reset, hold otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            mode_q <= clk_mode_e'(mode_sync_i);
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/cmrs_lock_model.sv
// Cycle-count stand-in for the loop lock. It counts input cycles while
// enabled, raises a sticky lock flag after LOCK_CYCLES counts, then counts
// MARGIN further cycles before it raises the release flag.
// Assumes: LOCK_CYCLES >= 2 and MARGIN >= 1; the synchronous reset clears all state.
module cmrs_lock_model #(
    parameter int LOCK_CYCLES = 2200,
    parameter int MARGIN      = 3
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    output logic locked_o,
    output logic release_o
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam int MRG_W = (MARGIN > 1) ? $clog2(MARGIN + 1) : 1;
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);
    localparam logic [MRG_W-1:0] MRG_LAST  = MRG_W'(MARGIN - 1);

    logic [CNT_W-1:0] lock_cnt_q;
    logic [MRG_W-1:0] mrg_cnt_q;
    logic             locked_q;
    logic             release_q;
    logic             counting;

    assign counting = run_i && !locked_q;

    // Count input cycles until the lock point.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            lock_cnt_q <= '0;
        end else if (counting) begin
            lock_cnt_q <= lock_cnt_q + 1'b1;
        end
    end

    // Raise the sticky lock flag on the last counted cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            locked_q <= 1'b0;
        end else if (counting && (lock_cnt_q == LOCK_LAST)) begin
            locked_q <= 1'b1;
        end
    end

    // Count the safety margin once locked.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            mrg_cnt_q <= '0;
        end else if (locked_q && !release_q) begin
            mrg_cnt_q <= mrg_cnt_q + 1'b1;
        end
    end

    // Raise the release flag when the margin has elapsed.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            release_q <= 1'b0;
        end else if (locked_q && (mrg_cnt_q == MRG_LAST)) begin
            release_q <= 1'b1;
        end
    end

    assign locked_o  = locked_q;
    assign release_o = release_q;
endmodule

// File: rtl/cmrs_div_enable.sv
// Core advance enable. In half-rate mode it alternates every cycle, starting
// high. In doubling mode it is high on every cycle. It is low in reset.
// Assumes: the mode is constant outside reset.
module cmrs_div_enable
    import cmrs_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_n_i,
    input  clk_mode_e mode_i,
    output logic      clk_en_o
);
    logic en_q;

    // Toggle or hold high according to the mode.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            en_q <= 1'b0;
        end else if (mode_i == MODE_HALF) begin
            en_q <= ~en_q;
        end else begin
            en_q <= 1'b1;
        end
    end

    assign clk_en_o = en_q;
endmodule

// File: rtl/clkmode_rst_seq.sv
// Top of the clock mode and reset release sequencer. It synchronizes and
// latches the mode pin during reset. It releases the core reset one cycle
// after the external reset in half-rate mode, or after the modelled lock
// plus a margin in doubling mode.
// Assumes: ext_rst_n_i is synchronous to clk_i; the mode pin is moved only during reset.
module clkmode_rst_seq
    import cmrs_pkg::*;
#(
    parameter int LOCK_CYCLES = 2200,
    parameter int MARGIN      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic ext_rst_n_i,
    input  logic mode_sel_i,
    output logic core_rst_n_o,
    output logic pll_locked_o,
    output logic clk_en_o
);
    logic      mode_sync;
    clk_mode_e mode_q;
    logic      loop_run;
    logic      loop_locked;
    logic      loop_release;
    logic      half_release_q;

    cmrs_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i(clk_i),
        .d_i  (mode_sel_i),
        .q_o  (mode_sync)
    );

    cmrs_mode_latch u_mode (
        .clk_i      (clk_i),
        .rst_n_i    (ext_rst_n_i),
        .mode_sync_i(mode_sync),
        .mode_o     (mode_q)
    );

    assign loop_run = (mode_q == MODE_DOUBLE);

    cmrs_lock_model #(
        .LOCK_CYCLES(LOCK_CYCLES),
        .MARGIN     (MARGIN)
    ) u_lock (
        .clk_i    (clk_i),
        .rst_n_i  (ext_rst_n_i),
        .run_i    (loop_run),
        .locked_o (loop_locked),
        .release_o(loop_release)
    );

    cmrs_div_enable u_en (
        .clk_i   (clk_i),
        .rst_n_i (ext_rst_n_i),
        .mode_i  (mode_q),
        .clk_en_o(clk_en_o)
    );

    // Half-rate release: one register stage behind the external reset.
    always_ff @(posedge clk_i) begin
        if (!ext_rst_n_i) begin
            half_release_q <= 1'b0;
        end else begin
            half_release_q <= 1'b1;
        end
    end

    // Pick the release source for the latched mode. Both sources are
    // registered and the mode is frozen outside reset, so the output stays glitch-free.
    assign core_rst_n_o = (mode_q == MODE_HALF) ? half_release_q : loop_release;
    assign pll_locked_o = loop_locked;
endmodule

// File: rtl/cmrs_checker.sv
// Property checker for clkmode_rst_seq, attached with bind. It watches the
// ports and the latched mode, and keeps its own cycle counters for the
// lock and margin windows.
module cmrs_checker
    import cmrs_pkg::*;
#(
    parameter int LOCK_CYCLES = 2200,
    parameter int MARGIN      = 3
) (
    input logic      clk_i,
    input logic      ext_rst_n_i,
    input logic      core_rst_n_o,
    input logic      pll_locked_o,
    input logic      clk_en_o,
    input clk_mode_e mode_q
);
    localparam int AGE_CAP = LOCK_CYCLES + MARGIN + 16;

    int  rel_age;
    int  lock_age;
    logic rst_seen_q = 1'b0;

    // Cycles since the external reset was released.
    always_ff @(posedge clk_i) begin
        if (!ext_rst_n_i) rel_age <= 0;
        else if (rel_age < AGE_CAP) rel_age <= rel_age + 1;
    end

    // Cycles for which the lock flag has been high.
    always_ff @(posedge clk_i) begin
        if (!ext_rst_n_i) lock_age <= 0;
        else if (pll_locked_o && lock_age < AGE_CAP) lock_age <= lock_age + 1;
    end

    // Remember whether the last edge sampled reset.
    always_ff @(posedge clk_i) begin
        rst_seen_q <= !ext_rst_n_i;
    end

    // R7: after a reset edge every output is low.
    always @(negedge clk_i) begin
        if (rst_seen_q) begin
            assert_reset_clears_R7: assert (!core_rst_n_o && !pll_locked_o && !clk_en_o)
                else $error("reset did not clear outputs");
        end
    end

    assert_half_no_lock_R1: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        (mode_q == MODE_HALF) |-> !pll_locked_o);

    assert_double_enable_R2: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        ((mode_q == MODE_DOUBLE) && $past(ext_rst_n_i)) |-> clk_en_o);

    assert_mode_frozen_R3: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        $past(ext_rst_n_i) |-> $stable(mode_q));

    assert_lock_time_R4: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        $rose(pll_locked_o) |-> (rel_age == LOCK_CYCLES));

    assert_lock_sticky_R4: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        pll_locked_o |=> pll_locked_o);

    assert_hold_until_lock_R5: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        ((mode_q == MODE_DOUBLE) && !pll_locked_o) |-> !core_rst_n_o);

    assert_margin_R5: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        ((mode_q == MODE_DOUBLE) && $rose(core_rst_n_o)) |-> (lock_age >= MARGIN));

    assert_half_toggle_R6: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        ((mode_q == MODE_HALF) && $past(ext_rst_n_i)) |-> (clk_en_o != $past(clk_en_o)));
endmodule

bind clkmode_rst_seq cmrs_checker #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .MARGIN     (MARGIN)
) u_checker (
    .clk_i       (clk_i),
    .ext_rst_n_i (ext_rst_n_i),
    .core_rst_n_o(core_rst_n_o),
    .pll_locked_o(pll_locked_o),
    .clk_en_o    (clk_en_o),
    .mode_q      (mode_q)
);

// File: tb/test_clkmode_rst_seq.sv
// Scoreboard bench: the driver queues expected output triples keyed by the
// cycle count since release, and a monitor pops and compares them.
module test_clkmode_rst_seq;
    localparam int LOCK = 2200;
    localparam int MRG  = 3;

    typedef struct {
        int    k;
        logic  rst_n;
        logic  lk;
        logic  en;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic ext_rst_n;
    logic mode_sel;
    logic core_rst_n;
    logic pll_locked;
    logic clk_en;

    int   ecnt   = 0;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    clkmode_rst_seq #(
        .LOCK_CYCLES(LOCK),
        .MARGIN     (MRG)
    ) i_clkmode_rst_seq (
        .clk_i       (clk),
        .ext_rst_n_i (ext_rst_n),
        .mode_sel_i  (mode_sel),
        .core_rst_n_o(core_rst_n),
        .pll_locked_o(pll_locked),
        .clk_en_o    (clk_en)
    );

    // Edges sampled with the external reset released.
    always @(posedge clk) begin
        if (!ext_rst_n) ecnt <= 0;
        else ecnt <= ecnt + 1;
    end

    task automatic compare(input string tag, input logic r, input logic l, input logic e);
        checks++;
        if (core_rst_n !== r || pll_locked !== l || clk_en !== e) begin
            fails++;
            $display("FAIL %s at k=%0d: rst_n/lock/en got %b%b%b expected %b%b%b",
                     tag, ecnt, core_rst_n, pll_locked, clk_en, r, l, e);
        end
    endtask

    // Monitor: pop and compare when the cycle count reaches the queue head.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && ext_rst_n && ecnt == sb_q[0].k) begin
            exp_t it;
            it = sb_q.pop_front();
            compare(it.tag, it.rst_n, it.lk, it.en);
        end
    end

    task automatic push(input int k, input logic r, input logic l, input logic e, input string tag);
        exp_t it;
        it.k = k; it.rst_n = r; it.lk = l; it.en = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Expected sequence for doubling mode.
    task automatic push_double(input string tag);
        push(1,            1'b0, 1'b0, 1'b1, tag);
        push(2,            1'b0, 1'b0, 1'b1, tag);
        push(LOCK - 1,     1'b0, 1'b0, 1'b1, tag);
        push(LOCK,         1'b0, 1'b1, 1'b1, tag);
        push(LOCK + MRG - 1, 1'b0, 1'b1, 1'b1, tag);
        push(LOCK + MRG,   1'b1, 1'b1, 1'b1, tag);
        push(LOCK + MRG + 10, 1'b1, 1'b1, 1'b1, tag);
    endtask

    task automatic release_run(input int n, input string tag);
        @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (n) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected items not consumed, expected 0", tag, sb_q.size());
            sb_q.delete();
        end
    endtask

    // Assert reset, check outputs after the first reset edge, hold n more cycles.
    task automatic enter_reset(input int n, input string tag);
        @(negedge clk);
        ext_rst_n = 1'b0;
        @(negedge clk);
        compare(tag, 1'b0, 1'b0, 1'b0);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        ext_rst_n = 1'b0;
        mode_sel  = 1'b0;
        repeat (6) @(negedge clk);
        compare("R7 reset state", 1'b0, 1'b0, 1'b0);

        // Half-rate run; the pin is flipped after release (R3).
        push(1,    1'b1, 1'b0, 1'b1, "R1");
        push(2,    1'b1, 1'b0, 1'b0, "R6");
        push(3,    1'b1, 1'b0, 1'b1, "R6");
        push(2300, 1'b1, 1'b0, 1'b0, "R3");
        @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (100) @(negedge clk);
        mode_sel = 1'b1;
        repeat (2220) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R3: %0d items left, expected 0", sb_q.size());
            sb_q.delete();
        end

        // Doubling mode after a reset from a running core.
        enter_reset(5, "R7 from half-rate");
        push_double("R4/R5 double");
        push(LOCK + MRG + 12, 1'b1, 1'b1, 1'b1, "R2");
        release_run(LOCK + MRG + 20, "R2");

        // Reset after lock, then reset mid-count: count restarts from zero.
        enter_reset(3, "R7 after lock");
        release_run(1000, "R7 partial");
        enter_reset(3, "R7 mid-count");
        push_double("R7 restart");
        release_run(LOCK + MRG + 20, "R7 restart");

        // Pin moved only on the last reset cycle: old mode (doubling) kept.
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        mode_sel = 1'b0;
        push(1, 1'b0, 1'b0, 1'b1, "R8 late change");
        push(2, 1'b0, 1'b0, 1'b1, "R8 late change");
        release_run(5, "R8 late change");

        // Same value held long enough: half-rate now applies.
        enter_reset(5, "R8 reset");
        push(1, 1'b1, 1'b0, 1'b1, "R8 settled");
        push(2, 1'b1, 1'b0, 1'b0, "R8 settled");
        release_run(5, "R8 settled");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule